// File: doc/BRIEF.md
# Flash Bulk Transfer FIFO Engine

This block sits between a host register bus and a word-wide flash-side port and moves bulk data through one 32-bit data FIFO. The FIFO sits behind a single data-port register. The host sees three word registers: a control/status word, a flash address pointer and the data port. To read flash, the host loads the address pointer and then writes the control word with a word count and the read-mode flag. The engine then fetches that many consecutive flash words into the FIFO and shows busy until the last word has landed. The host then drains the data port one word per access.

To write flash, the host stays out of read mode and pushes words into the same data port. The engine forwards each word to the flash side in order, at consecutive word addresses starting from the pointer. The host paces itself by polling the free-space field in the control word, and pushes a block only when that field shows the FIFO completely empty. A trailing partial word is handled by the host: it pads the word with zeros on write and drops the unused bytes on read. The engine itself only ever moves whole 32-bit words.

Top module: `flash_xfer_engine`

## Requirements
- R1: After reset the control word reads with the free-space field equal to DEPTH and every other bit zero, the address pointer reads 0, and no flash request is raised.
- R2: The register index selects the register: 0 is control/status, 1 is the address pointer and 2 is the data port. In the control word, bits [7:0] are the remaining read count, bit 8 is read mode, bit 9 is busy (read-only), bit 10 is the sticky underflow flag (read-only) and bits [23:16] are the FIFO free space (read-only).
- R3: A control write taken while idle with bit 8 set and a nonzero count N fetches min(N, DEPTH) words from consecutive flash addresses starting at the pointer. Busy is set from the cycle after that write. Busy clears only once the last fetched word is in the FIFO.
- R4: In read mode, each read of the data port returns the next fetched word in fetch order and removes it from the FIFO.
- R5: While busy, writes to the control word and to the address pointer have no effect.
- R6: A control write with bit 8 clear that is taken while idle ends read mode and discards any words left in the FIFO, so the free space returns to DEPTH.
- R7: The free-space field always equals DEPTH minus the number of words held in the FIFO.
- R8: Outside read mode, writes to the data port enter the FIFO. The engine writes them to flash in push order, at consecutive word addresses starting from the pointer. Data-port writes made in read mode are dropped.
- R9: A data-port read that finds the FIFO empty, or that is made outside read mode, returns 0, removes nothing and sets the underflow flag. The flag stays set until the next control write taken while idle.
- R10: A flash request holds its address, direction and write data steady until it is acknowledged. Only one request is outstanding at any time.
- R11: The address pointer reads back its current value, and it advances by one with each completed flash transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (pops the data port) |
| csr_idx | input | 2 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, valid in the same cycle as the index |
| fl_req | output | 1 | Flash transfer request, held until acknowledged |
| fl_we | output | 1 | 1 for a flash write, 0 for a flash read |
| fl_addr | output | FA_W | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_ack | input | 1 | One-cycle transfer acknowledge |
| fl_rdata | input | 32 | Flash read data, valid with fl_ack |

## Verification
The assertions check on every cycle that a pending flash request holds steady, and that the remaining count moves only on a flash acknowledge while busy. They also check that the underflow flag stays set until a control write, that the data port returns 0 when the FIFO is empty, that the occupancy never exceeds DEPTH, that no flash write starts in read mode, and that busy falls only on a completed fetch. The directed scenarios show what a single-cycle property cannot: whole read blocks returning the correct flash contents in order, the count clamped at DEPTH, commands dropped while busy, leftovers discarded when read mode ends, and write bursts landing at the right flash addresses.

// File: rtl/fxe_pkg.sv
package fxe_pkg;
  localparam int IDX_W = 2;
  localparam logic [IDX_W-1:0] IDX_CTRL = 2'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR = 2'd1;
  localparam logic [IDX_W-1:0] IDX_PORT = 2'd2;

  localparam int CNT_LSB   = 0;
  localparam int CNT_W     = 8;
  localparam int MODE_BIT  = 8;
  localparam int BUSY_BIT  = 9;
  localparam int UFLOW_BIT = 10;
  localparam int FREE_LSB  = 16;
  localparam int FREE_W    = 8;

  typedef enum logic {XFER_RD = 1'b0, XFER_WR = 1'b1} xfer_e;
endpackage

// File: rtl/fxe_fifo.sv
module fxe_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [AW:0]   count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != (AW+1)'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= din;
  end
endmodule

// File: rtl/fxe_seq.sv
module fxe_seq
  import fxe_pkg::*;
#(
  parameter int FA_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             ld_addr,
  input  logic [FA_W-1:0]  ld_val,
  input  logic             rd_mode,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_head,
  input  logic             fl_ack,
  output logic             fl_req,
  output logic             fl_we,
  output logic [FA_W-1:0]  fl_addr,
  output logic [31:0]      fl_wdata,
  output logic             fill,
  output logic             drain,
  output logic [CNT_W-1:0] rem,
  output logic [FA_W-1:0]  ptr
);
  logic             req_q, req_d;
  xfer_e            dir_q, dir_d;
  logic [FA_W-1:0]  ptr_q, ptr_d;
  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    req_d = req_q;
    dir_d = dir_q;
    ptr_d = ptr_q;
    rem_d = rem_q;
    if (req_q) begin
      if (fl_ack) begin
        req_d = 1'b0;
        ptr_d = ptr_q + 1'b1;
        if (dir_q == XFER_RD) rem_d = rem_q - 1'b1;
      end
    end else if (rem_q != '0) begin
      if (!fifo_full) begin
        req_d = 1'b1;
        dir_d = XFER_RD;
      end
    end else if (!rd_mode && !fifo_empty) begin
      req_d = 1'b1;
      dir_d = XFER_WR;
    end
    if (start)   rem_d = start_cnt;
    if (ld_addr) ptr_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      dir_q <= XFER_RD;
      ptr_q <= '0;
      rem_q <= '0;
    end else begin
      req_q <= req_d;
      dir_q <= dir_d;
      ptr_q <= ptr_d;
      rem_q <= rem_d;
    end
  end

  assign fl_req   = req_q;
  assign fl_we    = (dir_q == XFER_WR);
  assign fl_addr  = ptr_q;
  assign fl_wdata = fifo_head;
  assign fill     = req_q && fl_ack && (dir_q == XFER_RD);
  assign drain    = req_q && fl_ack && (dir_q == XFER_WR);
  assign rem      = rem_q;
  assign ptr      = ptr_q;
endmodule

// File: rtl/fxe_regs.sv
module fxe_regs
  import fxe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int FA_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  rem,
  input  logic [FA_W-1:0]   ptr,
  input  logic [FREE_W-1:0] free_sp,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [31:0]       fifo_head,
  output logic              start,
  output logic [CNT_W-1:0]  start_cnt,
  output logic              ld_addr,
  output logic              flush,
  output logic              host_push,
  output logic              host_pop,
  output logic              rd_mode,
  output logic              uflow
);
  logic             mode_q, mode_d, uflow_q, uflow_d;
  logic             ctrl_acc, port_rd, port_wr, port_ok;
  logic [CNT_W-1:0] wcnt;

  assign ctrl_acc  = csr_wr && (csr_idx == IDX_CTRL) && !busy;
  assign port_rd   = csr_rd && (csr_idx == IDX_PORT);
  assign port_wr   = csr_wr && (csr_idx == IDX_PORT);
  assign port_ok   = mode_q && !fifo_empty;
  assign wcnt      = csr_wdata[CNT_LSB +: CNT_W];
  assign start_cnt = (wcnt > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : wcnt;
  assign start     = ctrl_acc && csr_wdata[MODE_BIT] && (wcnt != '0);
  assign flush     = ctrl_acc && (mode_q || csr_wdata[MODE_BIT]);
  assign ld_addr   = csr_wr && (csr_idx == IDX_ADDR) && !busy;
  assign host_push = port_wr && !mode_q && !busy && !fifo_full;
  assign host_pop  = port_rd && port_ok;

  always_comb begin
    mode_d  = mode_q;
    uflow_d = uflow_q;
    if (ctrl_acc) begin
      mode_d  = csr_wdata[MODE_BIT];
      uflow_d = 1'b0;
    end
    if (port_rd && !port_ok) uflow_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      uflow_q <= uflow_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_idx)
      IDX_CTRL: begin
        csr_rdata[CNT_LSB +: CNT_W]   = rem;
        csr_rdata[MODE_BIT]           = mode_q;
        csr_rdata[BUSY_BIT]           = busy;
        csr_rdata[UFLOW_BIT]          = uflow_q;
        csr_rdata[FREE_LSB +: FREE_W] = free_sp;
      end
      IDX_ADDR: csr_rdata[FA_W-1:0] = ptr;
      IDX_PORT: if (port_ok) csr_rdata = fifo_head;
      default:  csr_rdata = '0;
    endcase
  end

  assign rd_mode = mode_q;
  assign uflow   = uflow_q;
endmodule

// File: rtl/flash_xfer_engine.sv
module flash_xfer_engine
  import fxe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int FA_W  = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic             csr_rd,
  input  logic [1:0]       csr_idx,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  output logic             fl_req,
  output logic             fl_we,
  output logic [FA_W-1:0]  fl_addr,
  output logic [31:0]      fl_wdata,
  input  logic             fl_ack,
  input  logic [31:0]      fl_rdata
);
  logic              busy, rd_mode, uflow;
  logic [CNT_W-1:0]  rem, start_cnt;
  logic [FA_W-1:0]   ptr;
  logic [AW:0]       fifo_cnt;
  logic [FREE_W-1:0] free_sp;
  logic              fifo_empty, fifo_full;
  logic [31:0]       fifo_head, fifo_din;
  logic              start, ld_addr, flush, host_push, host_pop, fill, drain;

  assign busy       = (rem != '0);
  assign fifo_empty = (fifo_cnt == '0);
  assign fifo_full  = (fifo_cnt == (AW+1)'(DEPTH));
  assign free_sp    = FREE_W'(DEPTH) - FREE_W'(fifo_cnt);
  assign fifo_din   = fill ? fl_rdata : csr_wdata;

  fxe_regs #(.DEPTH(DEPTH), .FA_W(FA_W)) u_regs (
    .clk, .rst_n, .csr_wr, .csr_rd, .csr_idx, .csr_wdata, .csr_rdata,
    .busy, .rem, .ptr, .free_sp, .fifo_empty, .fifo_full, .fifo_head,
    .start, .start_cnt, .ld_addr, .flush, .host_push, .host_pop,
    .rd_mode, .uflow
  );

  fxe_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .flush,
    .push (host_push | fill),
    .din  (fifo_din),
    .pop  (host_pop | drain),
    .dout (fifo_head),
    .count(fifo_cnt)
  );

  fxe_seq #(.FA_W(FA_W)) u_seq (
    .clk, .rst_n, .start, .start_cnt, .ld_addr,
    .ld_val (csr_wdata[FA_W-1:0]),
    .rd_mode, .fifo_full, .fifo_empty, .fifo_head, .fl_ack,
    .fl_req, .fl_we, .fl_addr, .fl_wdata, .fill, .drain, .rem, .ptr
  );
endmodule

// File: rtl/fxe_chk.sv
module fxe_chk #(
  parameter int DEPTH = 64,
  parameter int FA_W  = 24,
  parameter int AW    = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_wr,
  input logic            csr_rd,
  input logic [1:0]      csr_idx,
  input logic [31:0]     csr_rdata,
  input logic            fl_req,
  input logic            fl_we,
  input logic [FA_W-1:0] fl_addr,
  input logic [31:0]     fl_wdata,
  input logic            fl_ack,
  input logic            busy,
  input logic [7:0]      rem,
  input logic            rd_mode,
  input logic            uflow,
  input logic [AW:0]     fifo_cnt
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_we)
                             && (!fl_we || $stable(fl_wdata))));

  assert_rem_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fl_ack) |=> (rem == $past(rem)));

  assert_uflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !(csr_wr && csr_idx == 2'd0)) |=> uflow);

  assert_empty_port_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_idx == 2'd2 && fifo_cnt == '0) |-> (csr_rdata == 32'd0));

  assert_occupancy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= (AW+1)'(DEPTH));

  assert_no_write_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_req) && fl_we) |-> !rd_mode);

  assert_busy_ends_on_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fl_ack && !fl_we));
endmodule

bind flash_xfer_engine fxe_chk #(.DEPTH(DEPTH), .FA_W(FA_W), .AW(AW)) u_chk (
  .clk, .rst_n, .csr_wr, .csr_rd, .csr_idx, .csr_rdata,
  .fl_req, .fl_we, .fl_addr, .fl_wdata, .fl_ack,
  .busy, .rem, .rd_mode, .uflow, .fifo_cnt
);

// File: tb/flash_xfer_engine_bench.sv
`timescale 1ns/1ps
module flash_xfer_engine_bench;
  localparam int DEPTH = 64;
  localparam int FA_W  = 24;

  logic            clk, rst_n;
  logic            csr_wr, csr_rd;
  logic [1:0]      csr_idx;
  logic [31:0]     csr_wdata, csr_rdata;
  logic            fl_req, fl_we, fl_ack;
  logic [FA_W-1:0] fl_addr;
  logic [31:0]     fl_wdata, fl_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  flash_xfer_engine #(.DEPTH(DEPTH), .FA_W(FA_W)) u_flash_xfer_engine (
    .clk, .rst_n, .csr_wr, .csr_rd, .csr_idx, .csr_wdata, .csr_rdata,
    .fl_req, .fl_we, .fl_addr, .fl_wdata, .fl_ack, .fl_rdata
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {8'hC3, b, ~b, b ^ 8'h5A};
  endfunction

  // flash model: one-cycle acknowledge
  logic [31:0] fmem [256];
  initial for (int i = 0; i < 256; i++) fmem[i] = pat(i);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ack   <= 1'b0;
      fl_rdata <= '0;
    end else begin
      fl_ack <= fl_req && !fl_ack;
      if (fl_req && !fl_ack) begin
        if (fl_we) fmem[fl_addr[7:0]] <= fl_wdata;
        fl_rdata <= fmem[fl_addr[7:0]];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] idx, input logic [31:0] d);
    csr_wr = 1'b1; csr_idx = idx; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic csr_read(input logic [1:0] idx, output logic [31:0] d);
    csr_rd = 1'b1; csr_idx = idx;
    #1 d = csr_rdata;
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 1000; i++) begin
      csr_read(2'd0, v);
      if (!v[9]) break;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int cnt, input bit mode,
                                            input bit bsy, input bit uf, input int free);
    return (32'(free) << 16) | (32'(uf) << 10) | (32'(bsy) << 9) | (32'(mode) << 8) | 32'(cnt);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    csr_read(2'd0, v);
    check("R1/R2 reset ctrl", v, ctrl_word(0, 0, 0, 0, DEPTH));
    csr_read(2'd1, v);
    check("R1 reset pointer", v, 32'd0);
    check("R1 no flash req", {31'd0, fl_req}, 32'd0);
  endtask

  task automatic t_read_block();
    logic [31:0] v;
    csr_write(2'd1, 32'h10);
    csr_write(2'd0, 32'h105);
    csr_write(2'd1, 32'h80);   // ignored while busy
    csr_write(2'd0, 32'h103);  // ignored while busy
    csr_read(2'd0, v);
    check("R3 busy set", {31'd0, v[9]}, 32'd1);
    wait_idle();
    csr_read(2'd0, v);
    check("R3/R5/R7 ctrl after fetch", v, ctrl_word(0, 1, 0, 0, DEPTH - 5));
    csr_read(2'd1, v);
    check("R5/R11 pointer advanced", v, 32'h15);
    for (int i = 0; i < 5; i++) begin
      csr_read(2'd2, v);
      check("R4 drained word", v, pat(16 + i));
    end
    csr_read(2'd0, v);
    check("R7 free after drain", v, ctrl_word(0, 1, 0, 0, DEPTH));
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    csr_read(2'd2, v);
    check("R9 empty port read", v, 32'd0);
    csr_read(2'd0, v);
    check("R9 underflow set", v, ctrl_word(0, 1, 0, 1, DEPTH));
    csr_write(2'd0, 32'h0);
    csr_read(2'd0, v);
    check("R6/R9 ended and cleared", v, ctrl_word(0, 0, 0, 0, DEPTH));
  endtask

  task automatic t_leftover();
    logic [31:0] v;
    csr_write(2'd1, 32'h20);
    csr_write(2'd0, 32'h104);
    wait_idle();
    csr_read(2'd2, v);
    check("R4 first of four", v, pat(32));
    csr_read(2'd2, v);
    check("R4 second of four", v, pat(33));
    csr_write(2'd0, 32'h0);
    csr_read(2'd0, v);
    check("R6 leftover discarded", v, ctrl_word(0, 0, 0, 0, DEPTH));
    csr_read(2'd2, v);
    check("R9 outside read mode returns zero", v, 32'd0);
    csr_write(2'd0, 32'h0);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    csr_write(2'd1, 32'h0);
    csr_write(2'd0, 32'h100 | 32'd200);
    wait_idle();
    csr_read(2'd0, v);
    check("R3 count clamped to depth", v, ctrl_word(0, 1, 0, 0, 0));
    csr_read(2'd1, v);
    check("R3/R11 pointer after clamp", v, 32'(DEPTH));
    csr_read(2'd2, v);
    check("R4 clamp first word", v, pat(0));
    csr_write(2'd0, 32'h0);
  endtask

  task automatic t_port_write_in_read();
    logic [31:0] v;
    csr_write(2'd1, 32'h30);
    csr_write(2'd0, 32'h102);
    wait_idle();
    csr_write(2'd2, 32'hDEADBEEF);
    csr_read(2'd0, v);
    check("R8 push dropped in read mode", v, ctrl_word(0, 1, 0, 0, DEPTH - 2));
    csr_read(2'd2, v);
    check("R4 word 0x30", v, pat(48));
    csr_read(2'd2, v);
    check("R4 word 0x31", v, pat(49));
    csr_read(2'd2, v);
    check("R8/R9 no stray word", v, 32'd0);
    csr_write(2'd0, 32'h0);
  endtask

  task automatic t_write_path();
    logic [31:0] v;
    logic [31:0] w [3];
    w[0] = 32'h11112222; w[1] = 32'h33334444; w[2] = 32'h55556666;
    csr_write(2'd1, 32'h40);
    for (int i = 0; i < 3; i++) csr_write(2'd2, w[i]);
    for (int i = 0; i < 200; i++) begin
      csr_read(2'd0, v);
      if (v[23:16] == 8'(DEPTH) && !fl_req) break;
    end
    for (int i = 0; i < 3; i++) check("R8 flash word written", fmem[64 + i], w[i]);
    check("R8 next word untouched", fmem[67], pat(67));
    csr_read(2'd1, v);
    check("R11 pointer after writes", v, 32'h43);
    csr_read(2'd0, v);
    check("R2/R7 idle after writes", v, ctrl_word(0, 0, 0, 0, DEPTH));
  endtask

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_wr = 1'b0; csr_rd = 1'b0; csr_idx = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_block();
    t_underflow();
    t_leftover();
    t_clamp();
    t_port_write_in_read();
    t_write_path();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule